// File: doc/BRIEF.md
# DMA and CPU Memory-Access Priority Arbiter

This block decides, every cycle, which single requester may use a shared memory port: the processor or one of several DMA channels. Each channel carries a 2-bit priority code. The channels first compete among themselves. The highest level present wins, and a tie at that level is settled by a rotating round-robin pointer.

The single surviving channel then meets the processor. How that meeting ends depends on the channel's level. A high channel always takes the port. A low channel always gives way. A normal channel takes turns with the processor through a toggle bit, so it wins at least every second back-to-back conflict.

Grants are combinational from the requests, so a requester facing no competition is served in the cycle it asks. Only the round-robin pointer and the toggle bit are registered. The reset is synchronous and active high, and it forces all grants low.

Top module: `dma_cpu_arbiter`

## Requirements
- R1: While `rst` is high no grant is asserted. After reset the round-robin pointer is 0 and the normal-level toggle is clear.
- R2: At most one of `cpu_gnt` and `dma_gnt[*]` is high in any cycle. A grant only goes to a requester that is asserting its request in that cycle, and it is given in that same cycle.
- R3: Whenever at least one request is present outside reset, exactly one grant is asserted.
- R4: A granted-level DMA request whose level is high wins over a simultaneous CPU request in every cycle.
- R5: When the best DMA level present is low, a simultaneous CPU request wins in every cycle.
- R6: Call a cycle a normal conflict when the CPU requests and the best DMA level present is normal. In a normal conflict the DMA winner is granted if the toggle is clear, and the CPU is granted if it is set. Each normal conflict flips the toggle. Any other cycle clears it.
- R7: Among simultaneous DMA requests, a channel at a higher level always beats one at a lower level.
- R8: Among channels tied at the best level, the first one found scanning upward from the pointer (wrapping from the last index to 0) wins. The pointer moves to one past the winner, modulo the channel count, only in a cycle where a tie of two or more existed and the DMA winner was granted. Otherwise it stays unchanged.
- R9: The priority of channel i is `dma_prio[2i+1:2i]`. Code 00 is low and 01 is normal. Both 10 and 11 are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor requests the memory port |
| dma_req | input | NCH | Request per DMA channel |
| dma_prio | input | 2*NCH | Priority code per channel, channel i at bits 2i+1:2i |
| cpu_gnt | output | 1 | Processor is granted this cycle |
| dma_gnt | output | NCH | One-hot grant per DMA channel |

## Verification
Grants are due in the same cycle as the requests that cause them. The bench therefore drives inputs on the falling edge and compares the grants one time unit later, before the next rising edge. State results appear only in the grant of the following stimulus cycle, because the pointer and the toggle register their new values on the rising edge in between. These results are the toggle alternation, the toggle clear and the pointer movement. Each scenario starts from a fresh reset, so the expected pointer and toggle values are known from cycle counts alone.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int PRIO_W = 2;

    typedef enum logic [1:0] {
        LVL_LOW    = 2'd0,
        LVL_NORMAL = 2'd1,
        LVL_HIGH   = 2'd2
    } lvl_e;

    // Codes 10 and 11 both mean high.
    function automatic lvl_e decode_lvl(input logic [PRIO_W-1:0] code);
        case (code)
            2'b00:   return LVL_LOW;
            2'b01:   return LVL_NORMAL;
            default: return LVL_HIGH;
        endcase
    endfunction

endpackage

// File: rtl/arb_level_select.sv
module arb_level_select
    import arb_pkg::*;
#(
    parameter int NCH = 5
) (
    input  logic [NCH-1:0]        req,
    input  logic [PRIO_W*NCH-1:0] prio,
    output lvl_e                  top_lvl,
    output logic [NCH-1:0]        cand,
    output logic                  any_req
);
    lvl_e lvl [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign lvl[g] = decode_lvl(prio[PRIO_W*g +: PRIO_W]);
    end

    always_comb begin
        top_lvl = LVL_LOW;
        any_req = |req;
        for (int i = 0; i < NCH; i++) begin
            if (req[i] && (lvl[i] > top_lvl)) top_lvl = lvl[i];
        end
        for (int i = 0; i < NCH; i++) begin
            cand[i] = req[i] && (lvl[i] == top_lvl);
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int NCH = 5,
    localparam int PW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cand,
    input  logic           granted,
    output logic [PW-1:0]  win_idx,
    output logic           tie
);
    logic [PW-1:0] ptr_q;

    always_comb begin
        logic found;
        found   = 1'b0;
        win_idx = '0;
        for (int k = 0; k < NCH; k++) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= NCH) j = j - NCH;
            if (!found && cand[j]) begin
                found   = 1'b1;
                win_idx = PW'(j);
            end
        end
        tie = ($countones(cand) > 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (granted && tie) begin
            ptr_q <= (int'(win_idx) == NCH - 1) ? '0 : win_idx + 1'b1;
        end
    end
endmodule

// File: rtl/arb_cpu_resolve.sv
module arb_cpu_resolve
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_req,
    input  logic dma_any,
    input  lvl_e top_lvl,
    output logic cpu_win,
    output logic dma_win
);
    logic tog_q;
    logic normal_conflict;

    always_comb begin
        normal_conflict = cpu_req && dma_any && (top_lvl == LVL_NORMAL);
        dma_win = !rst && dma_any &&
                  (!cpu_req || (top_lvl == LVL_HIGH) ||
                   ((top_lvl == LVL_NORMAL) && !tog_q));
        cpu_win = !rst && cpu_req && !dma_win;
    end

    always_ff @(posedge clk) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= normal_conflict ? !tog_q : 1'b0;
    end
endmodule

// File: rtl/dma_cpu_arbiter.sv
module dma_cpu_arbiter
    import arb_pkg::*;
#(
    parameter int NCH = 5,
    localparam int PW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_req,
    input  logic [NCH-1:0]        dma_req,
    input  logic [PRIO_W*NCH-1:0] dma_prio,
    output logic                  cpu_gnt,
    output logic [NCH-1:0]        dma_gnt
);
    lvl_e          top_lvl;
    logic [NCH-1:0] cand;
    logic          dma_any;
    logic [PW-1:0] win_idx;
    logic          tie;
    logic          dma_win;

    arb_level_select #(.NCH(NCH)) u_lvl (
        .req     (dma_req),
        .prio    (dma_prio),
        .top_lvl (top_lvl),
        .cand    (cand),
        .any_req (dma_any)
    );

    arb_rr_pick #(.NCH(NCH)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .cand    (cand),
        .granted (dma_win),
        .win_idx (win_idx),
        .tie     (tie)
    );

    arb_cpu_resolve u_res (
        .clk     (clk),
        .rst     (rst),
        .cpu_req (cpu_req),
        .dma_any (dma_any),
        .top_lvl (top_lvl),
        .cpu_win (cpu_gnt),
        .dma_win (dma_win)
    );

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            dma_gnt[i] = dma_win && (win_idx == PW'(i));
        end
    end
endmodule

// File: rtl/dma_cpu_arbiter_chk.sv
module dma_cpu_arbiter_chk
    import arb_pkg::*;
#(
    parameter int NCH = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cpu_req,
    input logic [NCH-1:0]        dma_req,
    input logic [PRIO_W*NCH-1:0] dma_prio,
    input logic                  cpu_gnt,
    input logic [NCH-1:0]        dma_gnt
);
    lvl_e max_lvl;
    lvl_e gnt_lvl;
    logic nconf;

    always_comb begin
        max_lvl = LVL_LOW;
        gnt_lvl = LVL_LOW;
        for (int i = 0; i < NCH; i++) begin
            if (dma_req[i] && decode_lvl(dma_prio[PRIO_W*i +: PRIO_W]) > max_lvl)
                max_lvl = decode_lvl(dma_prio[PRIO_W*i +: PRIO_W]);
            if (dma_gnt[i]) gnt_lvl = decode_lvl(dma_prio[PRIO_W*i +: PRIO_W]);
        end
        nconf = cpu_req && (|dma_req) && (max_lvl == LVL_NORMAL);
    end

    AST_RESET_NO_GNT: assert property (@(posedge clk)
        rst |-> (!cpu_gnt && dma_gnt == '0));                               // R1
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_gnt, dma_gnt}));                                       // R2
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        ((dma_gnt & ~dma_req) == '0) && (!cpu_gnt || cpu_req));             // R2
    AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        (cpu_req || |dma_req) |-> (cpu_gnt || |dma_gnt));                   // R3
    AST_HIGH_BEATS_CPU: assert property (@(posedge clk) disable iff (rst)
        (|dma_req && max_lvl == LVL_HIGH) |-> !cpu_gnt);                     // R4
    AST_LOW_YIELDS: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && max_lvl == LVL_LOW) |-> cpu_gnt);                        // R5
    AST_NORMAL_ALT: assert property (@(posedge clk) disable iff (rst)
        (nconf && $past(nconf) && $past(cpu_gnt)) |-> (|dma_gnt));          // R6
    AST_DMA_TOP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (|dma_gnt) |-> (gnt_lvl == max_lvl));                                // R7
endmodule

bind dma_cpu_arbiter dma_cpu_arbiter_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_dma_cpu_arbiter.sv
module tb_dma_cpu_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cpu_req = 1'b0;
    logic [NCH-1:0] dma_req = '0;
    logic [2*NCH-1:0] dma_prio = '0;
    logic           cpu_gnt;
    logic [NCH-1:0] dma_gnt;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_cpu_arbiter #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .dma_req(dma_req),
        .dma_prio(dma_prio), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
    );

    // Codes: 00 low, 01 normal, 10/11 high; channel i at bits 2i+1:2i (R9)
    localparam logic [1:0] LO = 2'b00, NO = 2'b01, HI = 2'b10, HX = 2'b11;

    task automatic drive(input logic c, input logic [NCH-1:0] r,
                         input logic [1:0] p4, input logic [1:0] p3, input logic [1:0] p2,
                         input logic [1:0] p1, input logic [1:0] p0);
        @(negedge clk);
        cpu_req  = c;
        dma_req  = r;
        dma_prio = {p4, p3, p2, p1, p0};
        #1;
    endtask

    task automatic chk(input logic ec, input logic [NCH-1:0] ed, input string tag);
        n_chk++;
        if (cpu_gnt !== ec || dma_gnt !== ed) begin
            n_bad++;
            $display("FAIL %s: cpu_gnt=%b dma_gnt=%b expected cpu_gnt=%b dma_gnt=%b",
                     tag, cpu_gnt, dma_gnt, ec, ed);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_req = 1'b1; dma_req = 5'b10101; dma_prio = '1;
        #1;
        chk(1'b0, 5'b00000, "R1 grants low in reset");
        @(negedge clk);
        rst = 1'b0;
        cpu_req = 1'b0; dma_req = '0; dma_prio = '0;
        #1;
        chk(1'b0, 5'b00000, "R1 idle after reset");
    endtask

    task automatic t_single();
        do_reset();
        drive(1, 5'b00000, LO, LO, LO, LO, LO); chk(1, 5'b00000, "R2 lone CPU same cycle");
        drive(0, 5'b00100, LO, LO, LO, LO, LO); chk(0, 5'b00100, "R3 lone low channel");
        drive(0, 5'b00000, LO, LO, LO, LO, LO); chk(0, 5'b00000, "R2 no request no grant");
    endtask

    task automatic t_high();
        do_reset();
        for (int k = 0; k < 3; k++) begin
            drive(1, 5'b10000, HI, LO, LO, LO, LO); chk(0, 5'b10000, "R4 high beats CPU");
        end
        drive(1, 5'b00001, LO, LO, LO, LO, HX); chk(0, 5'b00001, "R9 code 11 is high");
    endtask

    task automatic t_low();
        do_reset();
        for (int k = 0; k < 3; k++) begin
            drive(1, 5'b00010, LO, LO, LO, LO, LO); chk(1, 5'b00000, "R5 low yields");
        end
    endtask

    task automatic t_normal();
        do_reset();
        drive(1, 5'b00001, LO, LO, LO, LO, NO); chk(0, 5'b00001, "R1 R6 first conflict DMA");
        drive(1, 5'b00001, LO, LO, LO, LO, NO); chk(1, 5'b00000, "R6 second conflict CPU");
        drive(1, 5'b00001, LO, LO, LO, LO, NO); chk(0, 5'b00001, "R6 third conflict DMA");
        drive(0, 5'b00000, LO, LO, LO, LO, NO); chk(0, 5'b00000, "R6 gap cycle");
        drive(1, 5'b00001, LO, LO, LO, LO, NO); chk(0, 5'b00001, "R6 toggle cleared by gap");
        drive(1, 5'b00001, LO, LO, LO, LO, NO); chk(1, 5'b00000, "R6 alternation resumes");
    endtask

    task automatic t_levels();
        do_reset();
        drive(0, 5'b01101, LO, HI, NO, LO, LO); chk(0, 5'b01000, "R7 high over normal/low");
        drive(0, 5'b10001, NO, LO, LO, LO, LO); chk(0, 5'b10000, "R7 normal over low");
        drive(1, 5'b00011, LO, LO, LO, LO, HI); chk(0, 5'b00001, "R7 high over low with CPU");
    endtask

    task automatic t_rr();
        do_reset();
        drive(0, 5'b10110, NO, LO, NO, NO, LO); chk(0, 5'b00010, "R8 tie from ptr 0");
        drive(0, 5'b10110, NO, LO, NO, NO, LO); chk(0, 5'b00100, "R8 tie ptr 2");
        drive(0, 5'b10110, NO, LO, NO, NO, LO); chk(0, 5'b10000, "R8 tie ptr 3");
        drive(0, 5'b10110, NO, LO, NO, NO, LO); chk(0, 5'b00010, "R8 wrap to ch1");
        drive(0, 5'b10000, NO, LO, LO, LO, LO); chk(0, 5'b10000, "R8 lone request");
        drive(0, 5'b10010, NO, LO, LO, NO, LO); chk(0, 5'b10000, "R8 ptr held without tie");
    endtask

    task automatic t_rr_lost();
        do_reset();
        drive(1, 5'b00101, LO, LO, LO, LO, LO); chk(1, 5'b00000, "R8 tie lost to CPU");
        drive(0, 5'b00101, LO, LO, LO, LO, LO); chk(0, 5'b00001, "R8 ptr held after lost tie");
    endtask

    initial begin
        t_single();
        t_high();
        t_low();
        t_normal();
        t_levels();
        t_rr();
        t_rr_lost();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule